// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit processor datapath. It takes a data word, a two-bit shift kind, an eight-bit shift count and the current carry flag. It returns the shifted word together with the carry that the shift produces. A select input says where the count came from. A count taken from an instruction's immediate field gives a count of zero a special meaning. A count taken from the low byte of a register gives the zero count no special meaning. Counts of 32 and above from a register are handled in full, up to 255.

The shifting logic is purely combinational. A thin wrapper registers its result. When the sample strobe is high, the wrapper captures the result on a clock edge. It shows the result one cycle later with a matching valid pulse. The wrapper keeps the last result while the strobe is low. The flag register and the ALU that use the carry live elsewhere.

Top module: `bshift_unit`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_result` and `out_carry` show that input's result after that edge and `out_valid` is high for that one cycle. When `in_valid` is low, `out_valid` is low and both outputs keep their value. A synchronous `rst` clears `out_valid`, `out_result` and `out_carry` to zero.
- R2: `in_kind` is encoded as 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R3: If `in_from_reg` is 1 and `in_amount` is 0, the result equals the input word and the carry-out equals `in_carry`, for every kind.
- R4: A logical left shift by n in 1..32 gives the input shifted left with zero fill, and carry-out is input bit 32-n. A logical left shift with an immediate count of 0 passes the word through and keeps the carry.
- R5: A logical left or logical right shift by more than 32 gives a zero result and carry-out 0.
- R6: A logical right shift by n in 1..32 gives the input shifted right with zero fill, and carry-out is input bit n-1. An immediate count of 0 acts as a shift by 32: the result is 0 and the carry-out is input bit 31.
- R7: An arithmetic right shift by n in 1..31 fills the top with input bit 31, and carry-out is input bit n-1. A count of 32 or more, or an immediate count of 0, makes every result bit and the carry-out equal to input bit 31.
- R8: A rotate right by a nonzero n rotates by n mod 32, and carry-out equals result bit 31. For example, n=32 returns the word unchanged with carry-out equal to bit 31.
- R9: A rotate right with an immediate count of 0 shifts right by one, puts `in_carry` into bit 31, and gives carry-out equal to input bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for the inputs |
| in_value | input | 32 | Word to shift |
| in_kind | input | 2 | Shift kind (R2 encoding) |
| in_amount | input | 8 | Shift count |
| in_from_reg | input | 1 | 1: count came from a register; 0: from an immediate field |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | High for one cycle after a sample |
| out_result | output | 32 | Registered shifted word |
| out_carry | output | 1 | Registered carry-out |

## Verification
The bound checker checks the following on every cycle:
- the valid pulse and the hold behaviour of the output register;
- pass-through for a zero count taken from a register;
- zero result and zero carry for logical left shifts above 32;
- sign fill for an arithmetic shift with an immediate zero count;
- the extended rotate;
- carry-out equal to result bit 31 for every nonzero rotate.

Some results depend on data bits and cannot be checked cycle by cycle. These include exact carry bit positions within the 1..32 range, rotate counts taken modulo 32, and logical right shifts with an immediate zero count. The bench shows them with its vector table and with a sweep over all kinds and counts against a bit-level model. Only the directed scenarios show that reset in the middle of traffic clears the outputs.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    OP_PASS  = 2'b00,
    OP_RRX   = 2'b01,
    OP_SHIFT = 2'b10
  } shift_op_e;
endpackage

// File: rtl/bshift_decode.sv
module bshift_decode
  import bshift_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int EFF_W = AMT_W + 1
) (
  input  shift_kind_e      kind,
  input  logic             from_reg,
  input  logic [AMT_W-1:0] amount,
  output shift_op_e        op,
  output logic [EFF_W-1:0] eff_amt
);
  localparam logic [EFF_W-1:0] FULL = EFF_W'(W);

  always_comb begin
    op      = OP_SHIFT;
    eff_amt = {1'b0, amount};
    if (amount == '0) begin
      if (from_reg) begin
        op = OP_PASS;
      end else begin
        unique case (kind)
          SH_LSL:         op = OP_PASS;
          SH_LSR, SH_ASR: eff_amt = FULL;
          default:        op = OP_RRX;
        endcase
      end
    end
  end
endmodule

// File: rtl/bshift_core.sv
module bshift_core
  import bshift_pkg::*;
#(
  parameter int W     = 32,
  parameter int EFF_W = 9
) (
  input  shift_kind_e      kind,
  input  shift_op_e        op,
  input  logic [EFF_W-1:0] eff_amt,
  input  logic [W-1:0]     value,
  input  logic             carry_in,
  output logic [W-1:0]     result,
  output logic             carry_out
);
  localparam logic [EFF_W-1:0] W_E = EFF_W'(W);

  logic [W:0]        lsl_w;
  logic [W:0]        lsr_w;
  logic signed [W:0] asr_w;
  logic [EFF_W-1:0]  asr_amt;
  logic [EFF_W-1:0]  rot_amt;
  logic [W-1:0]      rot_res;

  always_comb begin
    lsl_w   = {1'b0, value} << eff_amt;
    lsr_w   = {value, 1'b0} >> eff_amt;
    asr_amt = (eff_amt >= W_E) ? W_E : eff_amt;
    asr_w   = $signed({value, 1'b0}) >>> asr_amt;
    rot_amt = eff_amt % W_E;
    rot_res = (value >> rot_amt) | (value << (W_E - rot_amt));
  end

  always_comb begin
    result    = value;
    carry_out = carry_in;
    if (op == OP_RRX) begin
      result    = {carry_in, value[W-1:1]};
      carry_out = value[0];
    end else if (op == OP_SHIFT) begin
      unique case (kind)
        SH_LSL: begin
          result    = lsl_w[W-1:0];
          carry_out = lsl_w[W];
        end
        SH_LSR: begin
          result    = lsr_w[W:1];
          carry_out = lsr_w[0];
        end
        SH_ASR: begin
          result    = asr_w[W:1];
          carry_out = asr_w[0];
        end
        default: begin
          result    = rot_res;
          carry_out = rot_res[W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     in_value,
  input  logic [1:0]       in_kind,
  input  logic [AMT_W-1:0] in_amount,
  input  logic             in_from_reg,
  input  logic             in_carry,
  output logic             out_valid,
  output logic [W-1:0]     out_result,
  output logic             out_carry
);
  localparam int EFF_W = AMT_W + 1;

  shift_kind_e      kind;
  shift_op_e        op;
  logic [EFF_W-1:0] eff_amt;
  logic [W-1:0]     comb_res;
  logic             comb_carry;

  assign kind = shift_kind_e'(in_kind);

  bshift_decode #(.W(W), .AMT_W(AMT_W)) u_decode (
    .kind     (kind),
    .from_reg (in_from_reg),
    .amount   (in_amount),
    .op       (op),
    .eff_amt  (eff_amt)
  );

  bshift_core #(.W(W), .EFF_W(EFF_W)) u_core (
    .kind      (kind),
    .op        (op),
    .eff_amt   (eff_amt),
    .value     (in_value),
    .carry_in  (in_carry),
    .result    (comb_res),
    .carry_out (comb_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_carry  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= comb_res;
        out_carry  <= comb_carry;
      end
    end
  end
endmodule

// File: rtl/bshift_unit_chk.sv
module bshift_unit_chk #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [W-1:0]     in_value,
  input logic [1:0]       in_kind,
  input logic [AMT_W-1:0] in_amount,
  input logic             in_from_reg,
  input logic             in_carry,
  input logic             out_valid,
  input logic [W-1:0]     out_result,
  input logic             out_carry
);
  localparam logic [AMT_W-1:0] LIM = AMT_W'(W);

  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry)));

  p_reg_zero_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_from_reg && in_amount == '0) |=>
      (out_result == $past(in_value) && out_carry == $past(in_carry)));

  p_lsl_over_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'b00 && in_amount > LIM) |=>
      (out_result == '0 && !out_carry));

  p_asr_imm_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'b10 && !in_from_reg && in_amount == '0) |=>
      (out_result == {W{$past(in_value[W-1])}} && out_carry == $past(in_value[W-1])));

  p_ror_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'b11 && in_amount != '0) |=>
      (out_carry == out_result[W-1]));

  p_rrx_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 2'b11 && !in_from_reg && in_amount == '0) |=>
      (out_carry == $past(in_value[0]) && out_result[W-1] == $past(in_carry)
       && out_result[W-2:0] == $past(in_value[W-1:1])));
endmodule

bind bshift_unit bshift_unit_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_value    (in_value),
  .in_kind     (in_kind),
  .in_amount   (in_amount),
  .in_from_reg (in_from_reg),
  .in_carry    (in_carry),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_carry   (out_carry)
);

// File: tb/bshift_unit_tb.sv
module bshift_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_value = '0;
  logic [1:0]  in_kind = '0;
  logic [7:0]  in_amount = '0;
  logic        in_from_reg = 1'b0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_carry;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bshift_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_value(in_value),
    .in_kind(in_kind), .in_amount(in_amount), .in_from_reg(in_from_reg),
    .in_carry(in_carry), .out_valid(out_valid), .out_result(out_result),
    .out_carry(out_carry)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        fr;
    logic [7:0]  amt;
    logic        cin;
    logic [31:0] val;
    logic [31:0] res;
    logic        c;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 8'd1,   1'b0, 32'hC0000005, 32'h8000000A, 1'b1, 4'd4}, // R4 R2
    '{2'b00, 1'b1, 8'd32,  1'b0, 32'hC0000005, 32'h00000000, 1'b1, 4'd4}, // R4
    '{2'b00, 1'b1, 8'd33,  1'b1, 32'hC0000005, 32'h00000000, 1'b0, 4'd5}, // R5
    '{2'b00, 1'b0, 8'd0,   1'b1, 32'hC0000005, 32'hC0000005, 1'b1, 4'd4}, // R4
    '{2'b01, 1'b0, 8'd0,   1'b0, 32'hC0000005, 32'h00000000, 1'b1, 4'd6}, // R6
    '{2'b01, 1'b1, 8'd3,   1'b0, 32'hC0000005, 32'h18000000, 1'b1, 4'd6}, // R6
    '{2'b01, 1'b1, 8'd200, 1'b1, 32'hC0000005, 32'h00000000, 1'b0, 4'd5}, // R5
    '{2'b10, 1'b1, 8'd4,   1'b0, 32'hC0000005, 32'hFC000000, 1'b0, 4'd7}, // R7
    '{2'b10, 1'b0, 8'd0,   1'b0, 32'hC0000005, 32'hFFFFFFFF, 1'b1, 4'd7}, // R7
    '{2'b10, 1'b1, 8'd40,  1'b1, 32'h70000000, 32'h00000000, 1'b0, 4'd7}, // R7
    '{2'b11, 1'b1, 8'd4,   1'b0, 32'hC0000005, 32'h5C000000, 1'b0, 4'd8}, // R8
    '{2'b11, 1'b1, 8'd36,  1'b0, 32'hC0000005, 32'h5C000000, 1'b0, 4'd8}, // R8
    '{2'b11, 1'b1, 8'd32,  1'b0, 32'hC0000005, 32'hC0000005, 1'b1, 4'd8}, // R8
    '{2'b11, 1'b0, 8'd0,   1'b1, 32'hC0000005, 32'hE0000002, 1'b1, 4'd9}, // R9
    '{2'b11, 1'b0, 8'd0,   1'b0, 32'h00000002, 32'h00000001, 1'b0, 4'd9}, // R9
    '{2'b10, 1'b1, 8'd0,   1'b1, 32'hC0000005, 32'hC0000005, 1'b1, 4'd3}, // R3
    '{2'b11, 1'b1, 8'd0,   1'b0, 32'hC0000005, 32'hC0000005, 1'b0, 4'd3}, // R3
    '{2'b01, 1'b1, 8'd0,   1'b1, 32'hC0000005, 32'hC0000005, 1'b1, 4'd3}  // R3
  };

  task automatic check(input int req, input string what, input logic [31:0] got_r,
                       input logic got_c, input logic [31:0] exp_r, input logic exp_c);
    total++;
    if (got_r !== exp_r || got_c !== exp_c) begin
      bad++;
      $display("FAIL R%0d %s: got res=%h c=%b exp res=%h c=%b",
               req, what, got_r, got_c, exp_r, exp_c);
    end
  endtask

  task automatic apply(input logic [1:0] k, input logic fr, input logic [7:0] a,
                       input logic ci, input logic [31:0] v);
    @(negedge clk);
    in_kind = k; in_from_reg = fr; in_amount = a; in_carry = ci; in_value = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic model(input logic [1:0] k, input logic fr, input int a, input logic ci,
                       input logic [31:0] v, output logic [31:0] r, output logic c);
    int n;
    r = v; c = ci;
    if (fr && a == 0) return;
    case (k)
      2'b00: if (a != 0) begin
        for (int i = 0; i < 32; i++) r[i] = (i >= a) ? v[i-a] : 1'b0;
        c = (a <= 32) ? v[32-a] : 1'b0;
      end
      2'b01: begin
        n = (a == 0) ? 32 : a;
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : 1'b0;
        c = (n <= 32) ? v[n-1] : 1'b0;
      end
      2'b10: begin
        n = (a == 0) ? 32 : a;
        for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? v[i+n] : v[31];
        c = (n < 32) ? v[n-1] : v[31];
      end
      default: if (a == 0) begin
        for (int i = 0; i < 31; i++) r[i] = v[i+1];
        r[31] = ci; c = v[0];
      end else begin
        n = a % 32;
        for (int i = 0; i < 32; i++) r[i] = v[(i+n)%32];
        c = r[31];
      end
    endcase
  endtask

  function automatic int req_of(input logic [1:0] k, input logic fr, input int a);
    if (fr && a == 0) return 3;
    case (k)
      2'b00:   return (a > 32) ? 5 : 4;
      2'b01:   return (a > 32) ? 5 : 6;
      2'b10:   return 7;
      default: return (a == 0) ? 9 : 8;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: got done=0 exp done=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] er;
    logic ec;
    logic [31:0] vals [3] = '{32'hC0000005, 32'h7FFFFFFE, 32'h12345678};
    int amts [43];
    for (int i = 0; i <= 40; i++) amts[i] = i;
    amts[41] = 100; amts[42] = 255;

    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R1 reset valid: got %b exp 0", out_valid); end
    check(1, "reset outputs", out_result, out_carry, 32'h0, 1'b0);
    rst = 1'b0;

    // table walk, R2 encoding across all rows
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].kind, VECS[i].fr, VECS[i].amt, VECS[i].cin, VECS[i].val);
      total++;
      if (out_valid !== 1'b1) begin bad++; $display("FAIL R1 vec %0d valid: got %b exp 1", i, out_valid); end
      check(int'(VECS[i].req), $sformatf("vec %0d", i), out_result, out_carry, VECS[i].res, VECS[i].c);
    end

    // R1: hold while strobe low with different inputs
    apply(2'b00, 1'b1, 8'd4, 1'b0, 32'h0000_00F1);
    @(negedge clk);
    in_kind = 2'b11; in_amount = 8'd8; in_value = 32'hDEAD_BEEF; in_carry = 1'b1;
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R1 idle valid: got %b exp 0", out_valid); end
    check(1, "hold", out_result, out_carry, 32'h0000_0F10, 1'b0);

    // R1: mid-run reset clears outputs
    apply(2'b10, 1'b0, 8'd0, 1'b0, 32'h8000_0000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    total++;
    if (out_valid !== 1'b0) begin bad++; $display("FAIL R1 reset valid: got %b exp 0", out_valid); end
    check(1, "mid reset", out_result, out_carry, 32'h0, 1'b0);

    // sweep against the bit-level model
    foreach (vals[vi]) begin
      for (int k = 0; k < 4; k++) begin
        for (int f = 0; f < 2; f++) begin
          foreach (amts[ai]) begin
            apply(2'(k), 1'(f), 8'(amts[ai]), 1'(ai % 2), vals[vi]);
            model(2'(k), 1'(f), amts[ai], 1'(ai % 2), vals[vi], er, ec);
            check(req_of(2'(k), 1'(f), amts[ai]),
                  $sformatf("sweep k=%0d reg=%0d n=%0d", k, f, amts[ai]),
                  out_result, out_carry, er, ec);
          end
        end
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule